// File: doc/BRIEF.md
# Conditional Integer Execute Stage with Shifted Operand

This block is the integer execute step of a 32-bit load/store processor core. In one cycle it forms the second operand, evaluates the condition code against the incoming status flags, and runs one of sixteen logical or arithmetic operations. The result, a destination write enable, the updated flags and a status-restore request are registered at the next clock edge. The second operand is either an 8-bit constant rotated right by twice a 4-bit field, or a register value shifted left, shifted right logically or arithmetically, or rotated. The shift amount is a 5-bit constant or the low byte of a second register.

Operands arrive already read from the register file. The surrounding pipeline raises `issue` for each operation and consumes the registered outputs when `done` pulses. When the first operand is the program counter, the block adds one instruction size to model prefetch. When the destination is the program counter and flag setting is requested, the block does not compute flags. It asks the pipeline to copy the saved status word into the current one.

Top module: `dp_exec_stage`

## Requirements
- R1: While reset is held, and until the first issued operation, `done`, `result_we`, `restore_status`, `result` and `flags_out` are all zero. `rst_n` is asynchronous and active-low; its release is synchronised over two clock edges.
- R2: An operation presented with `issue`=1 appears on the outputs after the next rising edge, with `done`=1 for that one cycle. In a cycle without `issue`, `done` falls to 0 and `result`, `result_we`, `flags_out` and `restore_status` keep their values. `result` is loaded on every issue, whether or not the condition passes.
- R3: `cond` selects the condition. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V) and 14 always; 15 never passes. On a failed condition, `result_we`=0, `restore_status`=0 and `flags_out` equals `flags_in`. Flags are packed as N=bit 3, Z=bit 2, C=bit 1 and V=bit 0.
- R4: The arithmetic opcodes are 2 a−b, 3 b−a, 4 a+b, 5 a+b+C, 6 a−b+C−1, 7 b−a+C−1, 10 compare (a−b) and 11 compare-negative (a+b). For the subtracting forms, C is 1 exactly when no borrow occurs. For the adding forms, C is the carry out of bit 31.
- R5: For arithmetic opcodes, V is set on signed overflow; 0x7FFFFFFF+0x7FFFFFFF gives 0xFFFFFFFE with NZCV=1001.
- R6: The logical opcodes are 0 a&b, 1 a^b, 8 test (a&b), 9 test-equivalence (a^b), 12 a|b, 13 b, 14 a&~b and 15 ~b. For these, C takes the shifter carry-out and V keeps `flags_in` V.
- R7: When flags are computed, N is result bit 31 and Z is 1 exactly when the result is zero.
- R8: Opcodes 8 to 11 never assert `result_we`, but they update the flags like the others.
- R9: With `set_flags`=0, `flags_out` equals `flags_in`.
- R10: With the condition passing, `set_flags`=1 and `rd_is_pc`=1, `restore_status`=1 and `flags_out` equals `flags_in`. `result_we` still follows R8.
- R11: With `op2_imm`=1, the second operand is `imm8` rotated right by 2×`rot4`. The shifter carry is the old C when `rot4`=0 and operand bit 31 otherwise.
- R12: Shift types are encoded as 0 LSL, 1 LSR, 2 ASR and 3 ROR. With a 5-bit constant amount of 0, LSL passes the value and the old C, LSR and ASR act as shifts by 32, and ROR becomes a one-bit rotate through C (C into bit 31, bit 0 out as carry).
- R13: A register amount (`shift_by_reg`=1) uses `shift_reg_amt` (0 to 255). An amount of 0 passes the value and the old C. LSL/LSR by 32 give 0 with carry bit 0/bit 31, and by more than 32 give 0 with carry 0. ASR by 32 or more fills with the sign bit. ROR by a nonzero multiple of 32 gives the value with carry bit 31.
- R14: With `rn_is_pc`=1, the first operand is `rn_val`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Present an operation this cycle |
| opcode | input | 4 | Operation select |
| cond | input | 4 | Condition code |
| set_flags | input | 1 | Update flags when condition passes |
| rd_is_pc | input | 1 | Destination is the program counter |
| rn_val | input | 32 | First operand register value |
| rn_is_pc | input | 1 | First operand is the program counter |
| op2_imm | input | 1 | Second operand is a rotated constant |
| imm8 | input | 8 | Constant for the rotated form |
| rot4 | input | 4 | Half rotate amount for the constant |
| rm_val | input | 32 | Register to be shifted |
| shift_type | input | 2 | Shift kind |
| shift_by_reg | input | 1 | Amount from a register byte |
| shift_imm | input | 5 | Constant shift amount |
| shift_reg_amt | input | 8 | Low byte of the amount register |
| flags_in | input | 4 | Current NZCV |
| done | output | 1 | Outputs hold a newly issued operation |
| result | output | 32 | Operation result |
| result_we | output | 1 | Write result to destination |
| flags_out | output | 4 | New NZCV |
| restore_status | output | 1 | Copy saved status into current status |

## Verification
The hardest corners to reach are the shifter amounts with special meaning. These are a constant amount of zero for each of the four shift kinds, register amounts of exactly 32 and above 32, and ROR by multiples of 32. A uniform random shift amount rarely lands on them. The stimulus therefore draws register amounts from a biased set {0, 1, 31, 32, 33, 64, 255, random} and forces the constant amount to zero one time in four. Directed vectors pin the overflow, borrow, restore and never-condition cases with literal expected values.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;
  localparam int XLEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam int AMT_W = 8;
  localparam int IMM_W = 8;
  localparam int ROT_W = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/dp_op2_shifter.sv
module dp_op2_shifter
  import dp_exec_pkg::*;
(
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic [XLEN-1:0]  rm,
  input  logic [1:0]       sh_type,
  input  logic             by_reg,
  input  logic [SHW-1:0]   sh_imm,
  input  logic [AMT_W-1:0] sh_reg,
  input  logic             c_in,
  output logic [XLEN-1:0]  op2,
  output logic             c_out
);
  localparam int RAMT_W = ROT_W + 1;

  logic [XLEN-1:0]   imm_val;
  logic              imm_c;
  logic [XLEN-1:0]   reg_val;
  logic              reg_c;
  logic [AMT_W-1:0]  amt;
  logic              rrx;
  logic [SHW-1:0]    idx;
  logic [SHW-1:0]    rsub;
  logic [2*XLEN-1:0] dbl;
  logic [RAMT_W-1:0] ramt;

  // rotated constant
  always_comb begin
    ramt    = {rot, 1'b0};
    dbl     = {XLEN'(imm), XLEN'(imm)} >> ramt;
    imm_val = dbl[XLEN-1:0];
    imm_c   = (rot == '0) ? c_in : imm_val[XLEN-1];
  end

  // effective amount, folding the zero-amount constant encodings
  always_comb begin
    rrx = 1'b0;
    if (by_reg) begin
      amt = sh_reg;
    end else begin
      amt = AMT_W'(sh_imm);
      if (sh_imm == '0) begin
        case (shift_e'(sh_type))
          SH_LSR, SH_ASR: amt = AMT_W'(XLEN);
          SH_ROR:         rrx = 1'b1;
          default:        amt = '0;
        endcase
      end
    end
  end

  // register shifter
  always_comb begin
    reg_val = rm;
    reg_c   = c_in;
    idx     = '0;
    rsub    = amt[SHW-1:0];
    if (rrx) begin
      reg_val = {c_in, rm[XLEN-1:1]};
      reg_c   = rm[0];
    end else if (amt != '0) begin
      case (shift_e'(sh_type))
        SH_LSL: begin
          if (amt < AMT_W'(XLEN)) begin
            idx     = SHW'(XLEN - int'(amt));
            reg_val = rm << amt[SHW-1:0];
            reg_c   = rm[idx];
          end else begin
            reg_val = '0;
            reg_c   = (amt == AMT_W'(XLEN)) ? rm[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (amt < AMT_W'(XLEN)) begin
            idx     = SHW'(int'(amt) - 1);
            reg_val = rm >> amt[SHW-1:0];
            reg_c   = rm[idx];
          end else begin
            reg_val = '0;
            reg_c   = (amt == AMT_W'(XLEN)) ? rm[XLEN-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (amt < AMT_W'(XLEN)) begin
            idx     = SHW'(int'(amt) - 1);
            reg_val = $unsigned($signed(rm) >>> amt[SHW-1:0]);
            reg_c   = rm[idx];
          end else begin
            reg_val = {XLEN{rm[XLEN-1]}};
            reg_c   = rm[XLEN-1];
          end
        end
        default: begin
          if (rsub == '0) begin
            reg_val = rm;
            reg_c   = rm[XLEN-1];
          end else begin
            idx     = rsub - SHW'(1);
            reg_val = (rm >> rsub) | (rm << (SHW'(XLEN - int'(rsub))));
            reg_c   = rm[idx];
          end
        end
      endcase
    end
  end

  assign op2   = use_imm ? imm_val : reg_val;
  assign c_out = use_imm ? imm_c : reg_c;
endmodule

// File: rtl/dp_cond_check.sv
module dp_cond_check
  import dp_exec_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      f,
  output logic       pass
);
  always_comb begin
    case (cond)
      4'd0:    pass = f.z;
      4'd1:    pass = !f.z;
      4'd2:    pass = f.c;
      4'd3:    pass = !f.c;
      4'd4:    pass = f.n;
      4'd5:    pass = !f.n;
      4'd6:    pass = f.v;
      4'd7:    pass = !f.v;
      4'd8:    pass = f.c && !f.z;
      4'd9:    pass = !f.c || f.z;
      4'd10:   pass = (f.n == f.v);
      4'd11:   pass = (f.n != f.v);
      4'd12:   pass = !f.z && (f.n == f.v);
      4'd13:   pass = f.z || (f.n != f.v);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_exec_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sh_c,
  input  logic            c_in,
  input  logic            v_in,
  output logic [XLEN-1:0] res,
  output nzcv_t           f_calc,
  output logic            is_test
);
  logic [XLEN-1:0] x;
  logic [XLEN-1:0] y;
  logic            cin;
  logic            arith;
  logic [XLEN:0]   sum;
  logic [XLEN-1:0] lres;

  always_comb begin
    x     = a;
    y     = b;
    cin   = 1'b0;
    arith = 1'b1;
    case (alu_op_e'(op))
      OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1; end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0; end
      OP_ADC:         begin x = a; y = b;  cin = c_in; end
      OP_SBC:         begin x = a; y = ~b; cin = c_in; end
      OP_RSC:         begin x = b; y = ~a; cin = c_in; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, x} + {1'b0, y} + (XLEN+1)'(cin);

  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: lres = a & b;
      OP_EOR, OP_TEQ: lres = a ^ b;
      OP_ORR:         lres = a | b;
      OP_MOV:         lres = b;
      OP_BIC:         lres = a & ~b;
      default:        lres = ~b;
    endcase
  end

  always_comb begin
    res      = arith ? sum[XLEN-1:0] : lres;
    f_calc.n = res[XLEN-1];
    f_calc.z = (res == '0);
    if (arith) begin
      f_calc.c = sum[XLEN];
      f_calc.v = (x[XLEN-1] == y[XLEN-1]) && (res[XLEN-1] != x[XLEN-1]);
    end else begin
      f_calc.c = sh_c;
      f_calc.v = v_in;
    end
  end

  assign is_test = (op[3:2] == 2'b10);
endmodule

// File: rtl/dp_exec_stage.sv
module dp_exec_stage
  import dp_exec_pkg::*;
#(
  parameter int INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [3:0]  opcode,
  input  logic [3:0]  cond,
  input  logic        set_flags,
  input  logic        rd_is_pc,
  input  logic [31:0] rn_val,
  input  logic        rn_is_pc,
  input  logic        op2_imm,
  input  logic [7:0]  imm8,
  input  logic [3:0]  rot4,
  input  logic [31:0] rm_val,
  input  logic [1:0]  shift_type,
  input  logic        shift_by_reg,
  input  logic [4:0]  shift_imm,
  input  logic [7:0]  shift_reg_amt,
  input  logic [3:0]  flags_in,
  output logic        done,
  output logic [31:0] result,
  output logic        result_we,
  output logic [3:0]  flags_out,
  output logic        restore_status
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  nzcv_t           f_cur;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic            sh_c;
  logic            pass;
  logic [XLEN-1:0] alu_res;
  nzcv_t           f_calc;
  logic            is_test;

  logic [XLEN-1:0] res_d, res_q;
  logic            we_d, we_q;
  nzcv_t           flg_d, flg_q;
  logic            rst_d, rst_q;
  logic            done_q;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  assign f_cur = nzcv_t'(flags_in);
  assign op_a  = rn_val + (rn_is_pc ? XLEN'(INSN_BYTES) : '0);

  dp_op2_shifter u_shift (
    .use_imm (op2_imm),
    .imm     (imm8),
    .rot     (rot4),
    .rm      (rm_val),
    .sh_type (shift_type),
    .by_reg  (shift_by_reg),
    .sh_imm  (shift_imm),
    .sh_reg  (shift_reg_amt),
    .c_in    (f_cur.c),
    .op2     (op_b),
    .c_out   (sh_c)
  );

  dp_cond_check u_cond (
    .cond (cond),
    .f    (f_cur),
    .pass (pass)
  );

  dp_alu_core u_alu (
    .op      (opcode),
    .a       (op_a),
    .b       (op_b),
    .sh_c    (sh_c),
    .c_in    (f_cur.c),
    .v_in    (f_cur.v),
    .res     (alu_res),
    .f_calc  (f_calc),
    .is_test (is_test)
  );

  // next state
  always_comb begin
    res_d = alu_res;
    we_d  = pass && !is_test;
    rst_d = pass && set_flags && rd_is_pc;
    flg_d = (pass && set_flags && !rd_is_pc) ? f_calc : f_cur;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q  <= '0;
      we_q   <= 1'b0;
      flg_q  <= '0;
      rst_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= issue;
      if (issue) begin
        res_q <= res_d;
        we_q  <= we_d;
        flg_q <= flg_d;
        rst_q <= rst_d;
      end
    end
  end

  assign done           = done_q;
  assign result         = res_q;
  assign result_we      = we_q;
  assign flags_out      = flg_q;
  assign restore_status = rst_q;
endmodule

// File: rtl/dp_exec_chk.sv
module dp_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue,
  input logic [3:0]  opcode,
  input logic [3:0]  cond,
  input logic        set_flags,
  input logic [3:0]  flags_in,
  input logic        done,
  input logic [31:0] result,
  input logic        result_we,
  input logic [3:0]  flags_out,
  input logic        restore_status
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!done && $stable(result) && $stable(flags_out) && $stable(result_we)));

  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(issue));

  // R3
  never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cond) == 4'hF) |-> (!result_we && !restore_status && flags_out == $past(flags_in)));

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(opcode[3:2]) == 2'b10) |-> !result_we);

  // R9
  no_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(set_flags)) |-> (flags_out == $past(flags_in) && !restore_status));

  // R10
  restore_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && restore_status) |-> flags_out == $past(flags_in));

  // R6
  logic_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(opcode) inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
      |-> flags_out[0] == $past(flags_in[0]));
endmodule

bind dp_exec_stage dp_exec_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .issue          (issue),
  .opcode         (opcode),
  .cond           (cond),
  .set_flags      (set_flags),
  .flags_in       (flags_in),
  .done           (done),
  .result         (result),
  .result_we      (result_we),
  .flags_out      (flags_out),
  .restore_status (restore_status)
);

// File: tb/dp_exec_stage_tb.sv
module dp_exec_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [3:0]  opcode, cond, rot4, flags_in;
  logic        set_flags, rd_is_pc, rn_is_pc, op2_imm, shift_by_reg;
  logic [31:0] rn_val, rm_val;
  logic [7:0]  imm8, shift_reg_amt;
  logic [1:0]  shift_type;
  logic [4:0]  shift_imm;
  logic        done, result_we, restore_status;
  logic [31:0] result;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] e_res;
  logic        e_we, e_rst;
  logic [3:0]  e_flg;

  always #10 clk = ~clk;

  dp_exec_stage u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .cond(cond),
    .set_flags(set_flags), .rd_is_pc(rd_is_pc), .rn_val(rn_val),
    .rn_is_pc(rn_is_pc), .op2_imm(op2_imm), .imm8(imm8), .rot4(rot4),
    .rm_val(rm_val), .shift_type(shift_type), .shift_by_reg(shift_by_reg),
    .shift_imm(shift_imm), .shift_reg_amt(shift_reg_amt), .flags_in(flags_in),
    .done(done), .result(result), .result_we(result_we),
    .flags_out(flags_out), .restore_status(restore_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !cy || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1;           default: return 0;
    endcase
  endfunction

  task automatic model();
    logic [31:0] a, b, res, x, y;
    logic [63:0] t, u;
    logic        sc, cy, vv, cin, arith, sub;
    logic        pass;
    longint      s;
    int          amt;
    bit          rrx;
    cin = flags_in[1];
    a = rn_val + (rn_is_pc ? 32'd4 : 32'd0);
    if (op2_imm) begin
      t  = {24'd0, imm8, 24'd0, imm8} >> (2 * rot4);
      b  = t[31:0];
      sc = (rot4 == 0) ? cin : b[31];
    end else begin
      rrx = 0;
      amt = shift_by_reg ? int'(shift_reg_amt) : int'(shift_imm);
      if (!shift_by_reg && shift_imm == 0) begin
        if (shift_type == 2'd1 || shift_type == 2'd2) amt = 32;
        else if (shift_type == 2'd3) rrx = 1;
      end
      if (rrx) begin b = {cin, rm_val[31:1]}; sc = rm_val[0]; end
      else if (amt == 0) begin b = rm_val; sc = cin; end
      else begin
        case (shift_type)
          2'd0: begin t = {32'd0, rm_val} << amt; b = t[31:0]; sc = t[32]; end
          2'd1: begin t = {rm_val, 32'd0} >> amt; b = t[63:32]; sc = t[31]; end
          2'd2: begin
            t = $unsigned($signed({rm_val, 32'd0}) >>> ((amt > 63) ? 63 : amt));
            b = t[63:32]; sc = t[31];
          end
          default: begin t = {rm_val, rm_val} >> (amt % 32); b = t[31:0]; sc = b[31]; end
        endcase
      end
    end
    arith = 1; sub = 0; x = a; y = b;
    case (opcode)
      2, 10: begin sub = 1; x = a; y = b; cin = 1; end
      6:     begin sub = 1; x = a; y = b; cin = flags_in[1]; end
      3:     begin sub = 1; x = b; y = a; cin = 1; end
      7:     begin sub = 1; x = b; y = a; cin = flags_in[1]; end
      4, 11: begin x = a; y = b; cin = 0; end
      5:     begin x = a; y = b; cin = flags_in[1]; end
      default: arith = 0;
    endcase
    if (arith && sub) begin
      res = x - y - {31'd0, !cin};
      cy  = ({32'd0, x} >= ({32'd0, y} + {63'd0, !cin}));
      s   = longint'($signed(x)) - longint'($signed(y)) - longint'(!cin);
      vv  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else if (arith) begin
      u   = {32'd0, x} + {32'd0, y} + {63'd0, cin};
      res = u[31:0]; cy = u[32];
      s   = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
      vv  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (opcode)
        0, 8:  res = a & b;
        1, 9:  res = a ^ b;
        12:    res = a | b;
        13:    res = b;
        14:    res = a & ~b;
        default: res = ~b;
      endcase
      cy = sc; vv = flags_in[0];
    end
    pass  = cond_ok(cond, flags_in);
    e_res = res;
    e_we  = pass && !(opcode >= 8 && opcode <= 11);
    e_rst = pass && set_flags && rd_is_pc;
    e_flg = (pass && set_flags && !rd_is_pc) ? {res[31], res == 0, cy, vv} : flags_in;
  endtask

  task automatic defaults();
    issue = 0; opcode = 4'd13; cond = 4'd14; set_flags = 1; rd_is_pc = 0;
    rn_val = 0; rn_is_pc = 0; op2_imm = 0; imm8 = 0; rot4 = 0; rm_val = 0;
    shift_type = 0; shift_by_reg = 0; shift_imm = 0; shift_reg_amt = 0; flags_in = 0;
  endtask

  task automatic run_vec(input string tag);
    model();
    issue = 1;
    @(negedge clk);
    issue = 0;
    chk({tag, " done"}, {31'd0, done}, 32'd1);
    chk({tag, " result"}, result, e_res);
    chk({tag, " we"}, {31'd0, result_we}, {31'd0, e_we});
    chk({tag, " flags"}, {28'd0, flags_out}, {28'd0, e_flg});
    chk({tag, " restore"}, {31'd0, restore_status}, {31'd0, e_rst});
  endtask

  function automatic logic [7:0] pick_amt(input int r);
    case (r % 8)
      0: return 8'd0;  1: return 8'd1;  2: return 8'd31;  3: return 8'd32;
      4: return 8'd33; 5: return 8'd64; 6: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 flags", {28'd0, flags_out, result_we, restore_status}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {done, result_we, restore_status, flags_out, result[27:0]}, 32'd0);

    // R5 overflow on ADD
    opcode = 4'd4; rn_val = 32'h7FFFFFFF; rm_val = 32'h7FFFFFFF;
    run_vec("R5");
    chk("R5 literal result", result, 32'hFFFFFFFE);
    chk("R5 literal flags", {28'd0, flags_out}, 32'h9);

    // R2 hold without issue
    rn_val = 32'h1234; opcode = 4'd2;
    @(negedge clk);
    chk("R2 done low", {31'd0, done}, 32'd0);
    chk("R2 result held", result, 32'hFFFFFFFE);

    // R4 subtract equal -> Z, C
    defaults(); opcode = 4'd2; rn_val = 32'd77; rm_val = 32'd77;
    run_vec("R4 sub-eq");
    chk("R7 zero flags", {28'd0, flags_out}, 32'h6);
    // R4 SBC with C=0
    opcode = 4'd6; rn_val = 5; rm_val = 3; flags_in = 4'b0000;
    run_vec("R4 sbc");
    chk("R4 sbc literal", result, 32'd1);
    // R4 RSC with C=1
    opcode = 4'd7; rn_val = 5; rm_val = 3; flags_in = 4'b0010;
    run_vec("R4 rsc");

    // R3 failing EQ and never
    defaults(); opcode = 4'd0; cond = 4'd0; flags_in = 4'b1001; rn_val = 32'hFF; rm_val = 32'h0F;
    run_vec("R3 eq-fail");
    chk("R3 no write", {31'd0, result_we}, 32'd0);
    cond = 4'd15; flags_in = 4'b0100;
    run_vec("R3 never");
    cond = 4'd3; flags_in = 4'b0000;
    run_vec("R3 cc-pass");

    // R8 compare never writes
    defaults(); opcode = 4'd10; rn_val = 3; rm_val = 9;
    run_vec("R8 cmp");
    chk("R8 flags N", {28'd0, flags_out}, 32'h8);

    // R9 no set
    defaults(); opcode = 4'd4; set_flags = 0; flags_in = 4'b0110; rn_val = 1; rm_val = 32'hFFFFFFFF;
    run_vec("R9");

    // R10 restore request
    defaults(); opcode = 4'd15; rd_is_pc = 1; flags_in = 4'b0011; rm_val = 32'h0;
    run_vec("R10");
    chk("R10 literal", {28'd0, restore_status, result_we, flags_out[1:0]}, 32'hF);

    // R11 rotated constant
    defaults(); op2_imm = 1; imm8 = 8'hFF; rot4 = 4'd4;
    run_vec("R11 rot");
    chk("R11 literal", result, 32'hFF000000);
    rot4 = 0; imm8 = 8'h01; flags_in = 4'b0010;
    run_vec("R11 rot0 carry");

    // R6 logical carry from shifter, V kept
    defaults(); opcode = 4'd0; rn_val = 32'hFFFF0000; rm_val = 32'h80000001;
    shift_type = 2'd1; shift_imm = 5'd1; flags_in = 4'b0001;
    run_vec("R6");

    // R12 zero-amount encodings
    defaults(); rm_val = 32'h80000003; flags_in = 4'b0010;
    shift_type = 2'd1; run_vec("R12 lsr32");
    shift_type = 2'd2; run_vec("R12 asr32");
    shift_type = 2'd3; run_vec("R12 rrx");
    chk("R12 rrx literal", result, 32'hC0000001);
    shift_type = 2'd0; run_vec("R12 lsl0");

    // R13 register amounts
    defaults(); shift_by_reg = 1; rm_val = 32'h80000001;
    shift_type = 2'd0; shift_reg_amt = 8'd32; run_vec("R13 lsl32");
    shift_reg_amt = 8'd40; run_vec("R13 lsl40");
    shift_type = 2'd3; shift_reg_amt = 8'd64; run_vec("R13 ror64");
    shift_type = 2'd2; shift_reg_amt = 8'd200; run_vec("R13 asr200");

    // R14 PC as first operand
    defaults(); opcode = 4'd4; rn_is_pc = 1; rn_val = 32'h100; rm_val = 32'h10;
    run_vec("R14");
    chk("R14 literal", result, 32'h114);

    // random sweep
    for (int i = 0; i < 600; i++) begin
      opcode = 4'($urandom); flags_in = 4'($urandom);
      cond = ($urandom % 3 == 0) ? 4'($urandom) : 4'd14;
      set_flags = ($urandom % 4 != 0); rd_is_pc = ($urandom % 8 == 0);
      rn_val = $urandom; rn_is_pc = ($urandom % 8 == 0);
      op2_imm = ($urandom % 4 == 0); imm8 = 8'($urandom); rot4 = 4'($urandom);
      rm_val = ($urandom % 8 == 0) ? 32'h7FFFFFFF : $urandom;
      shift_type = 2'($urandom); shift_by_reg = $urandom % 2;
      shift_imm = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      shift_reg_amt = pick_amt(int'($urandom % 64));
      if (!cond_ok(cond, flags_in)) run_vec("R3 rand");
      else if (opcode >= 8 && opcode <= 11) run_vec("R8 rand");
      else if (opcode inside {[2:7]}) run_vec("R4 rand");
      else run_vec("R6 rand");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule